// File: doc/BRIEF.md
# Barrel Shifter with Carry Flag

This block is the combinational shift stage of a 32-bit processor datapath. In a single pass it moves an operand left or right by a given number of places, and it can also rotate the operand. It produces the shifted word together with updated negative, zero and carry flags. There are five operations. Left logical, right logical and right arithmetic are shifts. Rotate right is a plain rotation. The fifth operation rotates right by exactly one place through the incoming carry.

The shift distance comes from one of two sources. The first is an immediate field, which has a legal range for each operation; a distance outside that range raises an error output. The second is a register, of which only the low byte counts, so distances up to 255 are possible. The rules for distances of 32 and above follow what shifting one place at a time would produce. The carry is the last bit that left the word. A distance of zero passes the operand through and leaves the carry as it was. Flag writes can be turned off, and then all three flags pass through unchanged.

The design has no clock and no state. The house style names states and transitions, and this block has neither.

Top module: `barrel_shift_unit`

## Requirements
- R1: `op_sel` encodes the operation as follows: 3'b000 left logical, 3'b001 right logical, 3'b010 right arithmetic, 3'b011 rotate right, 3'b100 rotate right one place through carry. The codes 3'b101 to 3'b111 raise `amt_err`.
- R2: With `amt_is_imm`=1, the legal distances are 0..31 for left logical, 1..32 for right logical and right arithmetic, and 1..31 for rotate right. Any other value of the full `shift_amt` raises `amt_err`. The one-place rotate through carry ignores `shift_amt` and never raises `amt_err`.
- R3: With `amt_is_imm`=0, only `shift_amt[7:0]` sets the distance, and `shift_amt[31:8]` has no effect on any output.
- R4: A left logical shift by n in 1..32 gives `operand<<n`, with carry `operand[32-n]`. For n>32 the result is 0 and the carry is 0.
- R5: A right logical shift by n in 1..32 gives `operand>>n`, with carry `operand[n-1]`. For n>32 the result is 0 and the carry is 0.
- R6: A right arithmetic shift by n in 1..31 gives the sign-filled `operand>>>n`, with carry `operand[n-1]`. For n≥32 every result bit and the carry equal `operand[31]`.
- R7: Rotate right by a non-zero n rotates by n mod 32. The carry is bit 31 of the result, and this includes the case n mod 32 = 0, where the result equals the operand.
- R8: The one-place rotate through carry gives `{c_in, operand[31:1]}`, with carry `operand[0]`.
- R9: A distance of zero for any of the first four operations gives `result`=`operand` and leaves the carry equal to `c_in`. This covers an immediate left shift by 0, which acts as a move.
- R10: With `set_flags`=1, `n_out` is `result[31]`, `z_out` is 1 exactly when `result` is zero, and `c_out` is the carry defined in R4 to R9.
- R11: With `set_flags`=0, `n_out`, `z_out` and `c_out` equal `n_in`, `z_in` and `c_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (R1) |
| operand | input | 32 | Value to shift |
| shift_amt | input | 32 | Shift distance: an immediate value, or the register value whose low byte is used |
| amt_is_imm | input | 1 | 1 = distance is an immediate, 0 = distance comes from a register |
| n_in | input | 1 | Incoming negative flag |
| z_in | input | 1 | Incoming zero flag |
| c_in | input | 1 | Incoming carry flag |
| set_flags | input | 1 | Enables the flag update |
| result | output | 32 | Shifted value |
| n_out | output | 1 | Negative flag after the operation |
| z_out | output | 1 | Zero flag after the operation |
| c_out | output | 1 | Carry flag after the operation |
| amt_err | output | 1 | Illegal immediate distance or unknown operation |

## Verification
The bench sweeps every operation over register distances 0 to 40 and over 63, 64, 65, 95, 96, 128, 200, 254 and 255. It fills the upper register bits with junk, so a shifter that read more than the low byte would give wrong results at the distances it chooses. A design that took the carry from the wrong end at distance 32 would miss at that boundary. The same goes for a design that let a left or right logical shift above 32 keep a carry, or that stopped sign-filling an arithmetic shift of 32 or more. Another corner is a rotate by a multiple of 32, where a design that treated the distance as zero would keep the old carry instead of bit 31. The immediate sweep runs from 0 to 34 and also tries 255, which catches any range check that is off by one at either end of an operation's legal window.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_op_e;

endpackage

// File: rtl/shift_amount_sel.sv
module shift_amount_sel
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] shift_amt,
    input  logic              amt_is_imm,
    output logic [AMT_W-1:0]  eff_amt,
    output logic              amt_err
);
    localparam logic [DATA_W-1:0] IMM_FULL = DATA_W'(DATA_W);
    localparam logic [DATA_W-1:0] IMM_MAX1 = DATA_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] IMM_ONE  = DATA_W'(1);

    logic imm_bad;

    // Immediate and register distances share the low bits; only the check differs.
    assign eff_amt = shift_amt[AMT_W-1:0];

    always_comb begin
        imm_bad = 1'b0;
        unique case (op_sel)
            SH_LSL:         imm_bad = (shift_amt > IMM_MAX1);
            SH_LSR, SH_ASR: imm_bad = (shift_amt < IMM_ONE) || (shift_amt > IMM_FULL);
            SH_ROR:         imm_bad = (shift_amt < IMM_ONE) || (shift_amt > IMM_MAX1);
            SH_RRX:         imm_bad = 1'b0;
            default:        imm_bad = 1'b0;
        endcase
    end

    always_comb begin
        if (op_sel > 3'(SH_RRX)) amt_err = 1'b1;
        else                     amt_err = amt_is_imm & imm_bad;
    end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  eff_amt,
    input  logic              c_in,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    localparam int LOG_W = $clog2(DATA_W);
    localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DATA_W);

    logic [DATA_W:0]   lsl_w;
    logic [DATA_W:0]   lsr_w;
    logic [DATA_W:0]   asr_w;
    logic [AMT_W-1:0]  asr_amt;
    logic [LOG_W-1:0]  rot;
    logic [LOG_W:0]    rot_comp;
    logic [DATA_W-1:0] ror_r;

    // The extra bit catches the last bit shifted out.
    assign lsl_w    = {1'b0, operand} << eff_amt;
    assign lsr_w    = {operand, 1'b0} >> eff_amt;
    assign asr_amt  = (eff_amt > AMT_FULL) ? AMT_FULL : eff_amt;
    assign asr_w    = $signed({operand, 1'b0}) >>> asr_amt;
    assign rot      = eff_amt[LOG_W-1:0];
    assign rot_comp = (LOG_W+1)'(DATA_W) - {1'b0, rot};
    assign ror_r    = (operand >> rot) | (operand << rot_comp);

    always_comb begin
        result = operand;
        carry  = c_in;
        if (op_sel == 3'(SH_RRX)) begin
            result = {c_in, operand[DATA_W-1:1]};
            carry  = operand[0];
        end else if (eff_amt != '0) begin
            unique case (op_sel)
                SH_LSL: begin
                    result = lsl_w[DATA_W-1:0];
                    carry  = lsl_w[DATA_W];
                end
                SH_LSR: begin
                    result = lsr_w[DATA_W:1];
                    carry  = lsr_w[0];
                end
                SH_ASR: begin
                    result = asr_w[DATA_W:1];
                    carry  = asr_w[0];
                end
                SH_ROR: begin
                    result = ror_r;
                    carry  = ror_r[DATA_W-1];
                end
                default: begin
                    result = operand;
                    carry  = c_in;
                end
            endcase
        end
    end
endmodule

// File: rtl/shift_flag_update.sv
module shift_flag_update #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    input  logic              carry,
    input  logic              set_flags,
    input  logic              n_in,
    input  logic              z_in,
    input  logic              c_in,
    output logic              n_out,
    output logic              z_out,
    output logic              c_out
);
    always_comb begin
        if (set_flags) begin
            n_out = result[DATA_W-1];
            z_out = ~|result;
            c_out = carry;
        end else begin
            n_out = n_in;
            z_out = z_in;
            c_out = c_in;
        end
    end
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] shift_amt,
    input  logic              amt_is_imm,
    input  logic              n_in,
    input  logic              z_in,
    input  logic              c_in,
    input  logic              set_flags,
    output logic [DATA_W-1:0] result,
    output logic              n_out,
    output logic              z_out,
    output logic              c_out,
    output logic              amt_err
);
    logic [AMT_W-1:0] eff_amt;
    logic             carry;

    shift_amount_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
        .op_sel     (op_sel),
        .shift_amt  (shift_amt),
        .amt_is_imm (amt_is_imm),
        .eff_amt    (eff_amt),
        .amt_err    (amt_err)
    );

    shift_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dp (
        .op_sel  (op_sel),
        .operand (operand),
        .eff_amt (eff_amt),
        .c_in    (c_in),
        .result  (result),
        .carry   (carry)
    );

    shift_flag_update #(.DATA_W(DATA_W)) u_flags (
        .result    (result),
        .carry     (carry),
        .set_flags (set_flags),
        .n_in      (n_in),
        .z_in      (z_in),
        .c_in      (c_in),
        .n_out     (n_out),
        .z_out     (z_out),
        .c_out     (c_out)
    );
endmodule

// File: rtl/barrel_shift_unit_chk.sv
module barrel_shift_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic [2:0]        op_sel,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] shift_amt,
    input logic              amt_is_imm,
    input logic              n_in,
    input logic              z_in,
    input logic              c_in,
    input logic              set_flags,
    input logic [DATA_W-1:0] result,
    input logic              n_out,
    input logic              z_out,
    input logic              c_out,
    input logic              amt_err
);
    logic known;
    assign known = !$isunknown({op_sel, operand, shift_amt, amt_is_imm,
                                n_in, z_in, c_in, set_flags});

    always_comb begin
        if (known) begin
            // R9: a zero register distance moves the operand and keeps the carry
            if (!amt_is_imm && shift_amt[7:0] == 8'd0 && op_sel < 3'd4)
                a_r9_zero_keeps: assert (result == operand && c_out == c_in);
            // R11: flags untouched when updates are off
            if (!set_flags)
                a_r11_flags_pass: assert (n_out == n_in && z_out == z_in && c_out == c_in);
            // R10: a zero result can never read as negative
            if (set_flags && z_out)
                a_r10_zero_not_neg: assert (!n_out);
            // R4: left logical beyond the word clears result and carry
            if (!amt_is_imm && op_sel == 3'd0 && shift_amt[7:0] > 8'd32)
                a_r4_lsl_flush: assert (result == '0 && (!set_flags || !c_out));
            // R6: arithmetic right of 32 or more fills with the sign
            if (!amt_is_imm && op_sel == 3'd2 && shift_amt[7:0] >= 8'd32)
                a_r6_asr_fill: assert (result == {DATA_W{operand[DATA_W-1]}});
            // R8: the one-place rotate feeds the carry into the top bit
            if (op_sel == 3'd4)
                a_r8_rrx_top: assert (result[DATA_W-1] == c_in && !amt_err);
            // R2: a rotate-right immediate of zero is illegal
            if (amt_is_imm && op_sel == 3'd3 && shift_amt == '0)
                a_r2_ror_imm_zero: assert (amt_err);
        end
    end
endmodule

bind barrel_shift_unit barrel_shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .op_sel     (op_sel),
    .operand    (operand),
    .shift_amt  (shift_amt),
    .amt_is_imm (amt_is_imm),
    .n_in       (n_in),
    .z_in       (z_in),
    .c_in       (c_in),
    .set_flags  (set_flags),
    .result     (result),
    .n_out      (n_out),
    .z_out      (z_out),
    .c_out      (c_out),
    .amt_err    (amt_err)
);

// File: tb/test_barrel_shift_unit.sv
module test_barrel_shift_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [2:0]  op_sel;
    logic [31:0] operand, shift_amt, result;
    logic        amt_is_imm, n_in, z_in, c_in, set_flags;
    logic        n_out, z_out, c_out, amt_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_shift_unit i_barrel_shift_unit (
        .op_sel(op_sel), .operand(operand), .shift_amt(shift_amt),
        .amt_is_imm(amt_is_imm), .n_in(n_in), .z_in(z_in), .c_in(c_in),
        .set_flags(set_flags), .result(result), .n_out(n_out),
        .z_out(z_out), .c_out(c_out), .amt_err(amt_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s op=%0d amt=%0d imm=%0b opnd=%h actual=%h expected=%h",
                     req, op_sel, shift_amt, amt_is_imm, operand, act, exp);
        end
    endtask

    // Reference: shift one place at a time.
    task automatic ref_shift(input int op, input logic [31:0] a, input int n,
                             input logic cin, output logic [31:0] r, output logic c);
        r = a;
        c = cin;
        if (op == 4) begin
            c = a[0];
            r = {cin, a[31:1]};
        end else begin
            for (int i = 0; i < n; i++) begin
                case (op)
                    0: begin c = r[31]; r = {r[30:0], 1'b0}; end
                    1: begin c = r[0];  r = {1'b0, r[31:1]}; end
                    2: begin c = r[0];  r = {r[31], r[31:1]}; end
                    default: begin r = {r[0], r[31:1]}; c = r[31]; end
                endcase
            end
        end
    endtask

    function automatic bit imm_ok(input int op, input logic [31:0] a);
        case (op)
            0: return a <= 32'd31;
            1, 2: return a >= 32'd1 && a <= 32'd32;
            3: return a >= 32'd1 && a <= 32'd31;
            4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string op_req(input int op, input int n);
        if (op != 4 && n == 0) return "R9";
        case (op)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic apply_and_check(input int op, input logic [31:0] a,
                                   input logic [31:0] amt, input bit imm,
                                   input bit cin, input bit sf, input bit nin,
                                   input bit zin);
        logic [31:0] er;
        logic ec;
        bit eerr;
        int n;
        @(posedge clk);
        op_sel = 3'(op); operand = a; shift_amt = amt; amt_is_imm = imm;
        c_in = cin; set_flags = sf; n_in = nin; z_in = zin;
        @(negedge clk);
        n = imm ? int'(amt) : int'(amt[7:0]);
        eerr = (op > 4) || (imm && !imm_ok(op, amt));
        chk(amt_err == eerr, imm ? "R2" : (op > 4 ? "R1" : "R3"),
            32'(amt_err), 32'(eerr));
        if (!eerr) begin
            ref_shift(op, a, n, cin, er, ec);
            chk(result == er, imm ? op_req(op, n) : (amt[31:8] != 0 ? "R3" : op_req(op, n)),
                result, er);
            if (sf) begin
                chk(n_out == er[31] && z_out == (er == 0), "R10",
                    {30'd0, n_out, z_out}, {30'd0, er[31], er == 0});
                chk(c_out == ec, op_req(op, n), 32'(c_out), 32'(ec));
            end else begin
                chk(n_out == nin && z_out == zin && c_out == cin, "R11",
                    {29'd0, n_out, z_out, c_out}, {29'd0, nin, zin, cin});
            end
        end
    endtask

    initial begin
        logic [31:0] opnds [8];
        int amts [50];
        logic [31:0] lfsr;
        int na;
        opnds[0] = 32'h0000_0000; opnds[1] = 32'hFFFF_FFFF;
        opnds[2] = 32'h8000_0001; opnds[3] = 32'h1234_5678;
        opnds[4] = 32'hA5A5_5A5A; opnds[5] = 32'h7FFF_FFFE;
        lfsr = 32'hC0FF_EE11;
        for (int i = 6; i < 8; i++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            opnds[i] = lfsr;
        end
        na = 0;
        for (int i = 0; i <= 40; i++) begin amts[na] = i; na++; end
        amts[na++] = 63;  amts[na++] = 64;  amts[na++] = 65;
        amts[na++] = 95;  amts[na++] = 96;  amts[na++] = 128;
        amts[na++] = 200; amts[na++] = 254; amts[na++] = 255;

        op_sel = '0; operand = '0; shift_amt = '0; amt_is_imm = 1'b0;
        c_in = 1'b1; set_flags = 1'b0; n_in = 1'b1; z_in = 1'b0;
        @(negedge clk);
        // R9 / R11: idle state moves zero, keeps flags
        chk(result == 32'd0 && c_out && n_out && !z_out && !amt_err, "R9",
            result, 32'd0);

        // Register-sourced sweep, upper bits filled with junk for R3.
        for (int op = 0; op < 5; op++)
            for (int ai = 0; ai < na; ai++)
                for (int oi = 0; oi < 8; oi++)
                    for (int cf = 0; cf < 4; cf++) begin
                        logic [31:0] junk;
                        junk = (oi % 2 == 1) ? (opnds[oi] & 32'hFFFF_FF00) : 32'd0;
                        apply_and_check(op, opnds[oi], junk | 32'(amts[ai]), 1'b0,
                                        cf[0], cf[1], cf[0] ^ oi[0], ~cf[0]);
                    end

        // Immediate sweep, R2 range boundaries.
        for (int op = 0; op < 5; op++)
            for (int a = 0; a <= 35; a++)
                for (int oi = 0; oi < 8; oi += 3) begin
                    int av;
                    av = (a == 35) ? 255 : a;
                    apply_and_check(op, opnds[oi], 32'(av), 1'b1, oi[0], 1'b1, 1'b0, 1'b0);
                end
        // R2: large immediate with upper bits set, and immediate LSL #0 as move (R9)
        apply_and_check(1, opnds[3], 32'h0000_0120, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        apply_and_check(0, opnds[4], 32'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

        // R1: unknown op codes
        for (int op = 5; op < 8; op++)
            for (int m = 0; m < 2; m++)
                apply_and_check(op, opnds[3], 32'd4, m[0], 1'b0, 1'b1, 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule